// File: doc/BRIEF.md
# Multi-Mode Trace Capture Buffer

This block keeps a short history of program execution in a small circular memory while a tracing session is open. Each cycle it may receive an executed-instruction event (program counter plus a change-of-flow flag) and a memory/register access event (address plus data). A two-bit capture policy decides which of these events become entries: only flow changes, flow changes with back-to-back duplicates dropped, every access, or every executed instruction.

A one-bit alignment control picks how a trigger pulse shapes the record. With alignment at 0 the buffer records from the opening of the session, wraps over its oldest entries, and freezes on the trigger, so the trigger sits at the end of the history. With alignment at 1 nothing is kept until the trigger, recording starts on the trigger cycle, and it stops when the memory is full. After capture has ended, software drains entries oldest-first through a read strobe; the memory is visible only while the session enable is high.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset, and on the first cycle `trace_en` is seen high after being low, `count` and `rd_ptr` are 0, `capture_done` is 0, and no event is stored on that opening cycle.
- R2: With `mode` = 2'b00, an entry is stored only on a cycle with `pc_valid` and `cof` both high; the entry holds `pc` in bits [AW+DW-1:DW] and zero in bits [DW-1:0]. Access events are not stored.
- R3: With `mode` = 2'b01, entries are formed as in R2, but an entry equal to the last entry stored in the session is dropped.
- R4: With `mode` = 2'b10, every cycle with `acc_valid` high stores `acc_addr` in bits [AW+DW-1:DW] and `acc_data` in bits [DW-1:0]; instruction events are not stored.
- R5: With `mode` = 2'b11, every cycle with `pc_valid` high stores an entry formed as in R2, whatever `cof` is.
- R6: With `align_before` = 0, a store into a full buffer overwrites the oldest entry: `count` stays at DEPTH and `rd_ptr` advances by one, modulo DEPTH.
- R7: With `align_before` = 0, a `trigger` cycle stores that cycle's event if it qualifies and then sets `capture_done`; nothing is stored afterwards in the session.
- R8: With `align_before` = 1, no event is stored before the first `trigger`; the trigger cycle's own event is stored if it qualifies.
- R9: With `align_before` = 1, `capture_done` goes high on the store that makes `count` equal DEPTH, and storing stops.
- R10: When `trace_en`, `capture_done` and `rd_req` are high and `count` is non-zero, `rd_data` shows the oldest entry and, at the clock edge, `rd_ptr` advances by one modulo DEPTH and `count` falls by one; `rd_req` has no effect while `capture_done` is 0.
- R11: While `trace_en` is 0, `rd_data` is 0 and the stored entries, `count` and `rd_ptr` are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Tracing session enable; a rising level opens a new session |
| mode | input | 2 | Capture policy: 00 flow, 01 flow without repeats, 10 accesses, 11 every instruction |
| align_before | input | 1 | 1: recording starts at trigger; 0: trigger ends recording |
| trigger | input | 1 | Trigger pulse |
| pc_valid | input | 1 | An instruction executed this cycle |
| pc | input | AW | Program counter of that instruction |
| cof | input | 1 | That instruction changed the program flow |
| acc_valid | input | 1 | A memory or register access happened this cycle |
| acc_addr | input | AW | Access address |
| acc_data | input | DW | Access data |
| rd_req | input | 1 | Pop the oldest entry |
| rd_data | output | AW+DW | Oldest unread entry (0 while `trace_en` is low) |
| count | output | $clog2(DEPTH+1) | Number of stored, unread entries |
| rd_ptr | output | $clog2(DEPTH) | Memory slot of the oldest entry |
| capture_done | output | 1 | Recording has ended for this session |

## Verification
The bench builds the block with DEPTH = 4 and 8-bit address and data fields. The shallow memory lets a dozen instructions push the wrap-around overwrite of R6 several times over and lets the start-at-trigger run reach its full-stop of R9 within a few cycles. The narrow fields keep repeated program-counter values, needed to show the duplicate drop of R3, easy to build by hand.

// File: rtl/trace_capture_buf.sv
module trace_capture_buf #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 16,
  localparam int EW   = AW + DW,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trace_en,
  input  logic [1:0]    mode,
  input  logic          align_before,
  input  logic          trigger,
  input  logic          pc_valid,
  input  logic [AW-1:0] pc,
  input  logic          cof,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_data,
  input  logic          rd_req,
  output logic [EW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic [PW-1:0] rd_ptr,
  output logic          capture_done
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [EW-1:0] last_q;
  logic          last_vld, started_q, en_q;
  logic          ev;
  logic [EW-1:0] ent;

  always_comb begin
    case (mode)
      2'b00, 2'b01: begin ev = pc_valid & cof; ent = {pc, {DW{1'b0}}}; end
      2'b10:        begin ev = acc_valid;      ent = {acc_addr, acc_data}; end
      default:      begin ev = pc_valid;       ent = {pc, {DW{1'b0}}}; end
    endcase
  end

  wire open_s = trace_en & ~en_q;
  wire full   = (count == FULL_CNT);
  wire armed  = align_before ? (started_q | trigger) : 1'b1;
  wire dup    = (mode == 2'b01) & last_vld & (ent == last_q);
  wire live   = trace_en & ~open_s;
  wire cap    = live & ~capture_done & armed & ev & ~dup & ~(full & align_before);
  wire pop    = live & capture_done & rd_req & (count != '0);
  wire ovw    = cap & full;

  assign rd_data = trace_en ? mem[rd_ptr] : '0;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= trace_en;
    end
    if (!rst_n || open_s) begin
      count        <= '0;
      rd_ptr       <= '0;
      wr_ptr       <= '0;
      capture_done <= 1'b0;
      started_q    <= 1'b0;
      last_vld     <= 1'b0;
      last_q       <= '0;
    end else if (trace_en) begin
      if (cap) begin
        mem[wr_ptr] <= ent;
        wr_ptr      <= nxt(wr_ptr);
        last_q      <= ent;
        last_vld    <= 1'b1;
      end
      if (cap & ~full) count <= count + 1'b1;
      else if (pop)    count <= count - 1'b1;
      if (pop | ovw) rd_ptr <= nxt(rd_ptr);
      if (align_before & trigger) started_q <= 1'b1;
      if (!capture_done) begin
        if (!align_before && trigger) capture_done <= 1'b1;
        else if (align_before && (full || (cap && count == FULL_CNT - 1'b1)))
          capture_done <= 1'b1;
      end
    end
  end

  // R1
  open_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trace_en) |=> (count == '0 && rd_ptr == '0 && !capture_done));

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R8
  wait_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && align_before && !started_q && !trigger && !capture_done)
      |=> (count == $past(count)));

  // R9
  done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_done && trace_en && !open_s) |=> capture_done);

  // R10
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> ((count + 1'b1) == $past(count)));
endmodule

// File: tb/sim_trace_capture_buf.sv
module sim_trace_capture_buf;
  localparam int CLK = 10;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int EW = AW + DW;

  logic clk = 0, rst_n = 0, trace_en = 0, align_before = 0, trigger = 0;
  logic [1:0] mode = 0;
  logic pc_valid = 0, cof = 0, acc_valid = 0, rd_req = 0;
  logic [AW-1:0] pc = 0, acc_addr = 0;
  logic [DW-1:0] acc_data = 0;
  logic [EW-1:0] rd_data;
  logic [2:0] count;
  logic [1:0] rd_ptr;
  logic capture_done;

  trace_capture_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (.*);

  always #(CLK/2) clk = ~clk;

  logic [EW-1:0] q[$];
  logic [EW-1:0] m_last;
  bit m_lv, m_done, m_started, m_enq;
  int m_rp;
  int checks = 0, fails = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    bit ev; logic [EW-1:0] ent;
    if (!rst_n) begin
      q.delete(); m_done = 0; m_started = 0; m_lv = 0; m_rp = 0; m_enq = 0;
    end else begin
      if (trace_en && !m_enq) begin
        q.delete(); m_done = 0; m_started = 0; m_lv = 0; m_rp = 0;
      end else if (trace_en) begin
        if (rd_req && m_done && q.size() > 0) begin
          void'(q.pop_front()); m_rp = (m_rp + 1) % DEPTH;
        end else if (!m_done) begin
          if (mode == 2'b10) begin ev = acc_valid; ent = {acc_addr, acc_data}; end
          else if (mode == 2'b11) begin ev = pc_valid; ent = {pc, 8'h00}; end
          else begin ev = pc_valid && cof; ent = {pc, 8'h00}; end
          if (ev && (!align_before || m_started || trigger) &&
              !(mode == 2'b01 && m_lv && ent == m_last)) begin
            if (q.size() == DEPTH) begin
              if (!align_before) begin
                void'(q.pop_front()); m_rp = (m_rp + 1) % DEPTH;
                q.push_back(ent); m_last = ent; m_lv = 1;
              end
            end else begin
              q.push_back(ent); m_last = ent; m_lv = 1;
            end
          end
          if (align_before && trigger) m_started = 1;
          if (!align_before && trigger) m_done = 1;
          if (align_before && q.size() == DEPTH) m_done = 1;
        end
      end
      m_enq = trace_en;
    end
  end

  task automatic cyc();
    logic [EW-1:0] exp_d;
    bit bad;
    @(posedge clk);
    #(CLK/4);
    checks++;
    exp_d = (trace_en && q.size() > 0) ? q[0] : rd_data;
    if (!trace_en) exp_d = '0;
    bad = (count !== 3'(q.size())) || (rd_ptr !== 2'(m_rp)) ||
          (capture_done !== m_done) || (rd_data !== exp_d);
    if (bad) begin
      fails++;
      $display("FAIL %s: count=%0d rd_ptr=%0d done=%0b data=%h expected count=%0d rd_ptr=%0d done=%0b data=%h",
               cur_req, count, rd_ptr, capture_done, rd_data, q.size(), m_rp, m_done, exp_d);
    end
  endtask

  task automatic idle();
    pc_valid = 0; cof = 0; acc_valid = 0; trigger = 0; rd_req = 0;
  endtask

  task automatic instr(input logic [AW-1:0] p, input bit c);
    pc_valid = 1; pc = p; cof = c; cyc(); idle();
  endtask

  task automatic open(input logic [1:0] m, input bit a);
    trace_en = 0; idle(); cyc();
    mode = m; align_before = a; trace_en = 1; cyc();
  endtask

  task automatic drain();
    rd_req = 1;
    for (int i = 0; i < DEPTH + 2; i++) cyc();
    rd_req = 0;
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) cyc();
    rst_n = 1; cyc();
    trace_en = 1; pc_valid = 1; cof = 1; pc = 8'h11; cyc(); idle();
    cyc();

    cur_req = "R2";
    open(2'b00, 0);
    acc_valid = 1; acc_addr = 8'hAA; acc_data = 8'h55; cyc(); idle();
    for (int i = 0; i < 7; i++) instr(8'(i + 1), (i % 2) == 0);
    cur_req = "R6";
    for (int i = 0; i < 10; i++) instr(8'(8'h20 + i), 1'b1);
    cur_req = "R10";
    rd_req = 1; instr(8'h40, 1'b1); rd_req = 0;
    cur_req = "R7";
    pc_valid = 1; cof = 1; pc = 8'h77; trigger = 1; cyc(); idle();
    instr(8'h78, 1'b1);
    cur_req = "R10";
    drain();
    cur_req = "R11";
    trace_en = 0; repeat (2) cyc();

    cur_req = "R3";
    open(2'b01, 0);
    instr(8'h05, 1); instr(8'h05, 1); instr(8'h05, 1);
    instr(8'h07, 1); instr(8'h07, 1); instr(8'h05, 1);
    trigger = 1; cyc(); idle();
    drain();

    cur_req = "R4";
    open(2'b10, 0);
    for (int i = 0; i < 3; i++) begin
      acc_valid = 1; acc_addr = 8'(8'h60 + i); acc_data = 8'(8'hC0 + i);
      pc_valid = 1; pc = 8'(i); cof = 1; cyc(); idle();
      instr(8'h90, 1);
    end
    acc_valid = 1; acc_addr = 8'h6F; acc_data = 8'hEE; trigger = 1; cyc(); idle();
    drain();

    cur_req = "R8";
    open(2'b11, 1);
    for (int i = 0; i < 3; i++) instr(8'(8'h30 + i), 0);
    pc_valid = 1; pc = 8'h3A; trigger = 1; cyc(); idle();
    cur_req = "R5";
    instr(8'h3B, 0); instr(8'h3C, 1);
    cur_req = "R9";
    for (int i = 0; i < 4; i++) instr(8'(8'h50 + i), 0);
    cur_req = "R10";
    drain();
    cur_req = "R11";
    trace_en = 0; rd_req = 1; repeat (2) cyc(); rd_req = 0;
    trace_en = 0; cyc();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK * 100000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule